// File: doc/BRIEF.md
# Floating-Point Significand Rounding Unit

This block sits at the end of an add, subtract or multiply datapath. It receives a significand that has not yet been rounded, an m-bit field, together with the three extra bits the datapath kept below it: guard, round and sticky. A further flag tells it whether the datapath needs a one-position left shift to put the leading one back in the top position. The block first works out which bits are kept, which bit serves as the round bit and which bits fold into sticky. It then applies one of four rounding modes, chosen by the result sign and a 2-bit mode select, to decide whether one unit in the last place is added.

The rounded significand is registered and comes out one cycle after an input qualified by a valid strobe. The block also reports two flags. The first says the result is inexact. The second says the increment overflowed the significand, so the exponent stage must add one. Exponent arithmetic, special operands and exception traps belong to other stages.

Top module: `sig_round`

## Requirements
- R1: While reset is high, and at the first clock edge after reset, out_valid, out_sig, out_carry and out_inexact are all zero.
- R2: A result appears, with out_valid high, at the first rising clock edge after the edge that samples in_valid high. out_valid is low after any edge that samples in_valid low.
- R3: When in_shift is 0, the kept bits are in_sig. The effective round bit is in_guard, and the effective sticky bit is in_round OR in_sticky.
- R4: When in_shift is 1, the kept bits are in_sig[W-2:0] with in_guard appended as the new least significant bit, and in_sig[W-1] is dropped. The effective round bit is in_round, and the effective sticky bit is in_sticky.
- R5: With in_mode = 2'b00 (nearest, ties to even), one ulp is added exactly when R AND (S OR L) is 1, where L is bit 0 of the kept bits. A tie (R=1, S=0) therefore rounds up only when L is 1.
- R6: With in_mode = 2'b01 (toward zero), no increment ever happens. out_sig equals the kept bits.
- R7: With in_mode = 2'b10 (toward plus infinity), one ulp is added when in_sign is 0 (positive) and R OR S is 1.
- R8: With in_mode = 2'b11 (toward minus infinity), one ulp is added when in_sign is 1 (negative) and R OR S is 1.
- R9: When the increment overflows the W-bit kept field, out_sig is a one in bit W-1 with zeros below it, and out_carry is 1. Otherwise out_carry is 0.
- R10: out_inexact is R OR S, taken after the remapping of R3 and R4.
- R11: A cycle with in_valid low leaves out_sig, out_carry and out_inexact unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input qualifier |
| in_sig | input | W | Unrounded significand |
| in_guard | input | 1 | First bit below the significand |
| in_round | input | 1 | Second bit below the significand |
| in_sticky | input | 1 | OR of all lower bits |
| in_shift | input | 1 | One-position left postnormalization needed |
| in_sign | input | 1 | Result sign, 1 = negative |
| in_mode | input | 2 | Rounding mode select |
| out_valid | output | 1 | Result qualifier |
| out_sig | output | W | Rounded significand |
| out_carry | output | 1 | Increment overflowed, exponent must be incremented |
| out_inexact | output | 1 | Discarded bits were not all zero |

## Verification
The hardest case to reach from the ports is the overflow of the increment. It needs every kept bit to be one, and which bits are kept depends on the shift flag. With the shift applied, the guard bit becomes the lowest kept bit, so the input significand must be all ones below its top bit and the guard must be set. On top of that, the mode, the sign and the effective round and sticky bits must all call for an increment. The bench builds the unit with a 5-bit significand and sweeps every combination of significand, guard, round, sticky, shift, sign and mode. This reaches every overflow path and every tie in both shift positions. Each vector is followed by an idle cycle whose inputs are inverted, which checks that the registered result is held.

// File: rtl/sig_round_pkg.sv
package sig_round_pkg;

    // Rounding mode encoding on the in_mode port
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rmode_e;

    // Bits that steer the increment decision, after remapping
    typedef struct packed {
        logic lsb;   // least significant kept bit
        logic rnd;   // effective round bit
        logic stk;   // effective sticky bit
    } rbits_t;

    // Decision: add one ulp or not
    function automatic logic want_increment(rmode_e mode, logic neg, rbits_t b);
        logic any_lost;
        any_lost = b.rnd | b.stk;
        case (mode)
            RM_NEAR_EVEN: want_increment = b.rnd & (b.stk | b.lsb);
            RM_TO_ZERO:   want_increment = 1'b0;
            RM_TO_POS:    want_increment = ~neg & any_lost;
            RM_TO_NEG:    want_increment = neg & any_lost;
            default:      want_increment = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rnd_align.sv
module rnd_align
    import sig_round_pkg::*;
#(
    parameter int W = 24
) (
    input  logic [W-1:0] sig_i,
    input  logic         guard_i,
    input  logic         round_i,
    input  logic         sticky_i,
    input  logic         shift_i,
    output logic [W-1:0] kept_o,
    output rbits_t       bits_o
);
    always_comb begin
        if (shift_i) begin
            kept_o     = {sig_i[W-2:0], guard_i};
            bits_o.rnd = round_i;
            bits_o.stk = sticky_i;
        end else begin
            kept_o     = sig_i;
            bits_o.rnd = guard_i;
            bits_o.stk = round_i | sticky_i;
        end
        bits_o.lsb = kept_o[0];
    end
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
    import sig_round_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       sign_i,
    input  rbits_t     bits_i,
    output logic       inc_o,
    output logic       inexact_o
);
    always_comb begin
        inc_o     = want_increment(rmode_e'(mode_i), sign_i, bits_i);
        inexact_o = bits_i.rnd | bits_i.stk;
    end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int W = 24
) (
    input  logic [W-1:0] kept_i,
    input  logic         inc_i,
    output logic [W-1:0] sig_o,
    output logic         carry_o
);
    localparam logic [W-1:0] WRAP_VAL = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum;

    always_comb begin
        sum     = {1'b0, kept_i} + {{W{1'b0}}, inc_i};
        carry_o = sum[W];
        sig_o   = carry_o ? WRAP_VAL : sum[W-1:0];
    end
endmodule

// File: rtl/sig_round.sv
module sig_round
    import sig_round_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_sig,
    input  logic         in_guard,
    input  logic         in_round,
    input  logic         in_sticky,
    input  logic         in_shift,
    input  logic         in_sign,
    input  logic [1:0]   in_mode,
    output logic         out_valid,
    output logic [W-1:0] out_sig,
    output logic         out_carry,
    output logic         out_inexact
);
    localparam logic [W-1:0] TOP_ONE = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] kept;
    rbits_t       bits;
    logic         inc;
    logic         inexact;
    logic [W-1:0] rounded;
    logic         carry;

    rnd_align #(.W(W)) align_i (
        .sig_i    (in_sig),
        .guard_i  (in_guard),
        .round_i  (in_round),
        .sticky_i (in_sticky),
        .shift_i  (in_shift),
        .kept_o   (kept),
        .bits_o   (bits)
    );

    rnd_decide decide_i (
        .mode_i    (in_mode),
        .sign_i    (in_sign),
        .bits_i    (bits),
        .inc_o     (inc),
        .inexact_o (inexact)
    );

    rnd_incr #(.W(W)) incr_i (
        .kept_i  (kept),
        .inc_i   (inc),
        .sig_o   (rounded),
        .carry_o (carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_sig     <= '0;
            out_carry   <= 1'b0;
            out_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sig     <= rounded;
                out_carry   <= carry;
                out_inexact <= inexact;
            end
        end
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6
    to_zero_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b01 && !in_shift) |=> (out_sig == $past(in_sig) && !out_carry));

    // R9
    carry_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_carry) |-> (out_sig == TOP_ONE));

    // R10
    inexact_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_shift) |=> (out_inexact == $past(in_guard | in_round | in_sticky)));

    // R10
    inexact_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_shift) |=> (out_inexact == $past(in_round | in_sticky)));

    // R11
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_sig) && $stable(out_carry) && $stable(out_inexact)));

endmodule

// File: tb/sig_round_tb_top.sv
module sig_round_tb_top;
    localparam int W    = 5;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [W-1:0] in_sig;
    logic         in_guard, in_round, in_sticky, in_shift, in_sign;
    logic [1:0]   in_mode;
    logic         out_valid;
    logic [W-1:0] out_sig;
    logic         out_carry, out_inexact;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sig_round #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sig(in_sig),
        .in_guard(in_guard), .in_round(in_round), .in_sticky(in_sticky),
        .in_shift(in_shift), .in_sign(in_sign), .in_mode(in_mode),
        .out_valid(out_valid), .out_sig(out_sig), .out_carry(out_carry),
        .out_inexact(out_inexact)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 60000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        string mtag;
        string rtag;
        int kept, rr, ss, lsb, inc, sum, exp_sig, exp_c, exp_x;

        rst = 1'b1; in_valid = 1'b1; in_sig = '1; in_guard = 1'b1;
        in_round = 1'b1; in_sticky = 1'b1; in_shift = 1'b0; in_sign = 1'b0;
        in_mode = 2'b10;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
        chk(out_sig == '0, "R1", "out_sig", int'(out_sig), 0);
        chk(out_carry == 1'b0, "R1", "out_carry", int'(out_carry), 0);
        chk(out_inexact == 1'b0, "R1", "out_inexact", int'(out_inexact), 0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        // R1 / R2: no valid sampled yet
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(out_sig == '0, "R1", "out_sig after reset", int'(out_sig), 0);

        for (int m = 0; m < 4; m++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int sh = 0; sh < 2; sh++) begin
                    for (int v = 0; v <= MASK; v++) begin
                        for (int grs = 0; grs < 8; grs++) begin
                            in_valid  = 1'b1;
                            in_sig    = W'(v);
                            in_guard  = grs[2];
                            in_round  = grs[1];
                            in_sticky = grs[0];
                            in_shift  = sh[0];
                            in_sign   = sg[0];
                            in_mode   = m[1:0];

                            if (sh != 0) begin
                                kept = ((v << 1) | grs[2]) & MASK;
                                rr   = grs[1];
                                ss   = grs[0];
                                rtag = "R4";
                            end else begin
                                kept = v;
                                rr   = grs[2];
                                ss   = grs[1] | grs[0];
                                rtag = "R3";
                            end
                            lsb = kept & 1;
                            case (m)
                                0: begin inc = rr & (ss | lsb);          mtag = "R5"; end
                                1: begin inc = 0;                        mtag = "R6"; end
                                2: begin inc = (sg == 0) ? (rr | ss) : 0; mtag = "R7"; end
                                default: begin inc = (sg == 1) ? (rr | ss) : 0; mtag = "R8"; end
                            endcase
                            sum = kept + inc;
                            if (sum > MASK) begin
                                exp_sig = 1 << (W - 1);
                                exp_c   = 1;
                            end else begin
                                exp_sig = sum;
                                exp_c   = 0;
                            end
                            exp_x = rr | ss;

                            @(negedge clk);
                            // R2: result one edge after valid
                            chk(out_valid == 1'b1, "R2", "out_valid", int'(out_valid), 1);
                            chk(int'(out_sig) == exp_sig, {mtag, "/", rtag}, "out_sig",
                                int'(out_sig), exp_sig);
                            // R9: overflow flag
                            chk(int'(out_carry) == exp_c, "R9", "out_carry",
                                int'(out_carry), exp_c);
                            // R10: inexact after remap
                            chk(int'(out_inexact) == exp_x, "R10", "out_inexact",
                                int'(out_inexact), exp_x);

                            // R11: idle cycle with disturbed inputs
                            in_valid  = 1'b0;
                            in_sig    = ~W'(v);
                            in_guard  = ~grs[2];
                            in_round  = ~grs[1];
                            in_sticky = ~grs[0];
                            in_shift  = ~sh[0];
                            in_sign   = ~sg[0];
                            in_mode   = ~m[1:0];
                            @(negedge clk);
                            chk(out_valid == 1'b0, "R2", "out_valid idle", int'(out_valid), 0);
                            chk(int'(out_sig) == exp_sig, "R11", "out_sig held",
                                int'(out_sig), exp_sig);
                            chk(int'(out_carry) == exp_c && int'(out_inexact) == exp_x,
                                "R11", "flags held",
                                int'({out_carry, out_inexact}), (exp_c << 1) | exp_x);
                        end
                    end
                end
            end
        end
        finish_run();
    end
endmodule